// File: doc/BRIEF.md
# Prescaled Free-Running Counter with Overflow Flag

This block is a free-running up-counter for a microcontroller-style timer. It advances on the bus clock through a prescaler that divides by 1, 4, 8 or 16. When the count passes from all ones back to zero, the block sets a sticky overflow flag. An enable bit turns that flag into an interrupt request. Software reads the count one byte at a time through a small register port. The design keeps the two bytes coherent: reading the upper byte captures the lower byte.

The prescale code may only be changed during a short window after reset. Once that window has closed, writes to those two bits are dropped. The other bits of the same control byte stay writable. Software clears the overflow flag by writing a one to it.

Read data comes back one cycle after a read strobe, qualified by `reg_rvalid`. That result stream has no back-pressure: the consumer must take every beat in the cycle it is offered. Writes take effect at the clock edge that samples them.

Top module: `frc16_timer`

## Requirements
- R1: After reset the control byte (address 2) reads 0x00, the status byte (address 3) reads 0x00, and `ovf_irq` is low.
- R2: With prescale code 00, the count rises by one on every bus clock. A read strobe returns the count as it stood at the sampling edge: address 0 gives the bits above bit 7, zero-extended, and address 1 gives bits [7:0].
- R3: A read of address 0 captures the low byte. The next read of address 1 returns that captured byte, however many cycles later it comes.
- R4: A read of address 1 with no pending capture returns the live low byte. A read of address 1 consumes any pending capture.
- R5: Status bit 7 is set at the clock edge where the count wraps from all ones to zero. It is not set before that edge.
- R6: Writing status with bit 7 = 1 clears the flag. Writing bit 7 = 0 leaves it unchanged. A wrap in the same cycle wins over the clear.
- R7: `ovf_irq` is high exactly while status bit 7 and control bit 7 (interrupt enable) are both 1.
- R8: Control bits [1:0] (prescale code) accept writes only during the first LOCK_CYCLES clock edges after reset. Later writes to them are ignored, while control bits [7:2] stay writable.
- R9: Prescale codes 01, 10 and 11 divide the bus clock by 4, 8 and 16. The wrap period is therefore the divide factor times 2^CNT_W bus cycles.
- R10: A reset issued mid-run returns the control and status bytes to 0x00 and lowers `ovf_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 2 | Register address: 0 count high, 1 count low, 2 control, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read result valid, one cycle after `reg_rd` |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with CNT_W = 10 and LOCK_CYCLES = 64. The shorter counter brings wrap periods down to 1024 cycles at divide-by-1 and 16384 at divide-by-16. That lets every prescale factor be timed from one wrap to the next, and lets a wrap be observed well after the lock window has closed. The upper byte then carries two live bits, so both the carry into it and the coherent capture of the lower byte are exercised.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int BYTE_W      = 8;
  localparam int DIV_W       = 4;
  localparam int CTRL_IE_BIT = 7;
  localparam int STAT_OVF_BIT = 7;
  localparam int PS_W        = 2;

  typedef enum logic [1:0] {
    ADDR_CNT_HI = 2'd0,
    ADDR_CNT_LO = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_STAT   = 2'd3
  } frc_addr_e;

  // Low-order mask of the divider that must be all ones for a tick.
  function automatic logic [DIV_W-1:0] div_mask(input logic [PS_W-1:0] code);
    case (code)
      2'b00:   div_mask = 4'b0000;
      2'b01:   div_mask = 4'b0011;
      2'b10:   div_mask = 4'b0111;
      default: div_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler
  import frc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = div_mask(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick = ((div_q & mask) == mask);
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  assign wrap = tick && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/frc_regs.sv
module frc_regs
  import frc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOCK_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              ovf_flag,
  output logic              locked
);
  localparam int LCW     = $clog2(LOCK_CYCLES + 1);
  localparam int EXT_W   = 2 * BYTE_W;
  localparam int CNT_PAD = EXT_W - CNT_W;

  logic [EXT_W-1:0]  cnt_ext;
  logic [LCW-1:0]    age_q;
  logic [BYTE_W-1:0] lo_hold_q;
  logic              hold_vld_q;
  frc_addr_e         addr;

  assign addr = frc_addr_e'(reg_addr);

  generate
    if (CNT_PAD > 0) begin : g_pad
      assign cnt_ext = {{CNT_PAD{1'b0}}, count};
    end else begin : g_nopad
      assign cnt_ext = count[EXT_W-1:0];
    end
  endgenerate

  // Window after reset during which the prescale code is writable.
  assign locked = (age_q == LCW'(LOCK_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       age_q <= '0;
    else if (!locked) age_q <= age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (reg_wr && addr == ADDR_CTRL) begin
      if (locked) ctrl_q <= {reg_wdata[BYTE_W-1:PS_W], ctrl_q[PS_W-1:0]};
      else        ctrl_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_flag <= 1'b0;
    else if (wrap)
      ovf_flag <= 1'b1;
    else if (reg_wr && addr == ADDR_STAT && reg_wdata[STAT_OVF_BIT])
      ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      lo_hold_q  <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        case (addr)
          ADDR_CNT_HI: begin
            reg_rdata  <= cnt_ext[EXT_W-1:BYTE_W];
            lo_hold_q  <= cnt_ext[BYTE_W-1:0];
            hold_vld_q <= 1'b1;
          end
          ADDR_CNT_LO: begin
            reg_rdata  <= hold_vld_q ? lo_hold_q : cnt_ext[BYTE_W-1:0];
            hold_vld_q <= 1'b0;
          end
          ADDR_CTRL: reg_rdata <= ctrl_q;
          default:   reg_rdata <= {ovf_flag, {(BYTE_W-1){1'b0}}};
        endcase
      end
    end
  end
endmodule

// File: rtl/frc16_timer.sv
module frc16_timer
  import frc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOCK_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       reg_rvalid,
  output logic       ovf_irq
);
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] count;
  logic [7:0]       ctrl_q;
  logic             ovf_flag;
  logic             locked;

  frc_prescaler u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (ctrl_q[PS_W-1:0]),
    .tick  (tick)
  );

  frc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .count (count),
    .wrap  (wrap)
  );

  frc_regs #(.CNT_W(CNT_W), .LOCK_CYCLES(LOCK_CYCLES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .count      (count),
    .wrap       (wrap),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .ctrl_q     (ctrl_q),
    .ovf_flag   (ovf_flag),
    .locked     (locked)
  );

  assign ovf_irq = ovf_flag & ctrl_q[CTRL_IE_BIT];
endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_addr,
  input logic             clr_bit,
  input logic             reg_rvalid,
  input logic             ovf_irq,
  input logic             tick,
  input logic             wrap,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             irq_en,
  input logic [1:0]       ps_code,
  input logic             locked
);
  logic stat_clr;
  assign stat_clr = reg_wr && (reg_addr == 2'd3) && clr_bit;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == $past(count) + 1'b1));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  assert_read_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !wrap) |=> !ovf_flag);
  assert_flag_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && !wrap) |=> $stable(ovf_flag));
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (irq_en && ovf_flag));
  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && ovf_flag) |-> ovf_irq);
  assert_ps_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ps_code));
endmodule

bind frc16_timer frc_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .clr_bit    (reg_wdata[7]),
  .reg_rvalid (reg_rvalid),
  .ovf_irq    (ovf_irq),
  .tick       (tick),
  .wrap       (wrap),
  .count      (count),
  .ovf_flag   (ovf_flag),
  .irq_en     (ctrl_q[7]),
  .ps_code    (ctrl_q[1:0]),
  .locked     (locked)
);

// File: tb/test_frc16_timer.sv
module test_frc16_timer;
  localparam int CNT_W = 10;
  localparam int LOCK  = 64;
  localparam int PERIOD0 = 1 << CNT_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_rvalid;
  logic       ovf_irq;

  int n_checks = 0;
  int n_fail = 0;
  int edges = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  frc16_timer #(.CNT_W(CNT_W), .LOCK_CYCLES(LOCK)) i_frc16_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .ovf_irq(ovf_irq)
  );

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  task automatic chk(input int act, input int exp, input string t);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  // Scoreboard monitor: every read beat pops one expected byte.
  always @(negedge clk) begin
    if (reg_rvalid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R3: unexpected read beat actual %0d expected none", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(reg_rdata, e, t);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_to(input int target);
    while (edges < target) @(negedge clk);
  endtask

  task automatic wait_irq(output int at);
    int guard = 0;
    while (!ovf_irq && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    at = edges;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] lo_saved;
    int e1, e2;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(2'd2, 8'h00, "R1 ctrl after reset");
    rd(2'd3, 8'h00, "R1 status after reset");
    chk(ovf_irq, 0, "R1 irq after reset");

    // R2/R3 coherent pair, R4 live low read
    wait_to(300);
    lo_saved = 8'(edges);
    rd(2'd0, 8'((edges >> 8) & 3), "R2 high byte");
    repeat (5) @(negedge clk);
    rd(2'd1, lo_saved, "R3 captured low byte");
    rd(2'd1, 8'(edges), "R4 live low byte");
    rd(2'd1, 8'(edges), "R4 live low again");

    // R5 not before the wrap, then set
    wait_to(PERIOD0 - 14);
    rd(2'd3, 8'h00, "R5 flag before wrap");
    wait_to(PERIOD0 + 6);
    rd(2'd3, 8'h80, "R5 flag after wrap");
    chk(ovf_irq, 0, "R7 irq masked while enable is 0");

    // R6 write 0 keeps flag
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h80, "R6 write 0 keeps flag");

    // R8 lock: ps ignored, other bits taken
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'hFC, "R8 prescale bits locked");
    chk(ovf_irq, 1, "R7 irq with flag and enable");
    wr(2'd3, 8'h80);
    chk(ovf_irq, 0, "R7 irq drops after clear");
    rd(2'd3, 8'h00, "R6 write 1 clears flag");
    lo_saved = 8'(edges);
    rd(2'd0, 8'((edges >> 8) & 3), "R8 high byte still divide-by-1");
    rd(2'd1, lo_saved, "R8 low byte still divide-by-1");
    wr(2'd2, 8'h7C);
    rd(2'd2, 8'h7C, "R8 upper control bits writable");

    // R10 mid-run reset
    wr(2'd2, 8'h80);
    wait_to(2 * PERIOD0 + 4);
    chk(ovf_irq, 1, "R7 irq on second wrap");
    do_reset();
    chk(ovf_irq, 0, "R10 irq after reset");
    rd(2'd2, 8'h00, "R10 ctrl after reset");
    rd(2'd3, 8'h00, "R10 status after reset");

    // R9 prescale factors, code written inside the window
    for (int code = 1; code < 4; code++) begin
      int factor;
      factor = (code == 1) ? 4 : (code == 2) ? 8 : 16;
      do_reset();
      wr(2'd2, 8'(8'h80 | code));
      rd(2'd2, 8'(8'h80 | code), "R9 code accepted in window");
      wait_irq(e1);
      wr(2'd3, 8'h80);
      wait_irq(e2);
      chk(e2 - e1, factor * PERIOD0, "R9 wrap period");
    end

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R3: actual %0d pending reads expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule